// File: doc/BRIEF.md
# Memory-Mapped Interval Timer

This block is a 32-bit down-counting interval timer that software programs through a small word-addressed register bus with separate read and write strobes. The live count moves down one step per clock while the timer runs. When it has passed through zero it raises a timeout flag, reloads the programmed period, and either keeps counting (continuous mode) or halts (one-shot mode). A level interrupt follows the timeout flag when interrupts are enabled.

The 32-bit period is written as two 16-bit halves. Writing either half halts the timer and reloads the counter at once. Software reads the running count by writing to either snapshot register, which copies both halves of the count in one cycle, and then reading the two snapshot words at its own pace. Start and stop are one-shot command bits inside a control write. Only the interrupt-enable and continuous-mode bits are kept.

Top module: `ival_timer`

## Requirements
- R1: After reset every register reads as zero, the interrupt is low, the timer is stopped, and the counter holds 0xFFFFFFFF, which a snapshot then shows as 0xFFFF in both halves.
- R2: The word index is `bus_addr[ADDR_W-1:2]` and byte bits [1:0] are ignored. Indices 0 to 5 are status, control, period low, period high, snapshot low and snapshot high. Indices 6 and 7 read as zero, and writes to them change nothing.
- R3: Control bit 0 (interrupt enable) and bit 1 (continuous mode) are stored. A control read returns only these two bits, and bits 2 and 3 always read as zero.
- R4: Control bit 2 starts the timer only when it is stopped, and control bit 3 stops it only when it is running. When both are set in one write to an idle timer, the start is applied first and then the stop, so the timer ends stopped.
- R5: A write to either period word stores data bits [15:0], clears the running flag, and loads the counter with the new combined value {high, low}.
- R6: While the timer runs, the count drops by one per clock, so one cycle through a period P takes P+1 clocks.
- R7: In the clock where a running count is zero, the timeout flag sets and the counter reloads the period. In continuous mode the timer keeps running.
- R8: On expiry in one-shot mode the running flag clears and the counter holds at the period value.
- R9: Any write to status clears the timeout flag, whatever the data. An expiry in the same clock wins, and the flag stays set.
- R10: A write to either snapshot word copies the count as it stood in that clock into snapshot low (bits [15:0]) and snapshot high (bits [31:16]) together.
- R11: `irq` is a level equal to the timeout flag AND the interrupt enable bit, both as they stand after each clock.
- R12: Status bit 0 is the timeout flag and bit 1 is the running flag. `bus_rdata` is registered: it shows the addressed word in the clock after `bus_rd`, holds between reads, and its bits above 15 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the counting tick |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data; bits [15:0] are used |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach from the ports are a bus write that lands in the same clock as an expiry: a status clear racing a new timeout, a one-shot expiry meeting a start command, or a snapshot taken at the reload. Directed phases use periods of one to four clocks and issue writes every clock, so these collisions happen many times. A long random phase also keeps periods below six and mixes start, stop, mode changes, snapshots and period writes at random byte addresses. Every read and every clock's interrupt level is compared against a bench-side model of the register rules.

// File: rtl/ival_timer_pkg.sv
package ival_timer_pkg;
  // register word indices
  localparam int IX_STAT = 0;
  localparam int IX_CTRL = 1;
  localparam int IX_PLO  = 2;
  localparam int IX_PHI  = 3;
  localparam int IX_SLO  = 4;
  localparam int IX_SHI  = 5;
  localparam int NREG    = 6;
  // status bits
  localparam int ST_TO   = 0;
  localparam int ST_RUN  = 1;
  // control bits
  localparam int CT_IE   = 0;
  localparam int CT_CONT = 1;
  localparam int CT_GO   = 2;
  localparam int CT_HALT = 3;
endpackage

// File: rtl/ival_decode.sv
module ival_decode #(
  parameter int ADDR_W = 5,
  parameter int NREG   = 6,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [IDX_W-1:0]  idx,
  output logic [NREG-1:0]   we
);
  assign idx = addr[ADDR_W-1:2];

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign we[g] = wr && (idx == IDX_W'(g));
  end

  always_comb begin
    a_r2_one_strobe: assert ($onehot0(we));
  end
endmodule

// File: rtl/ival_counter.sv
module ival_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt    = cnt_q;
  assign expire = run && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '1;
    else if (load)   cnt_q <= load_val;
    else if (expire) cnt_q <= reload;
    else if (run)    cnt_q <= cnt_q - CNT_W'(1);
  end

  a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt_q == $past(reload));
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(load_val));
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/ival_regs.sv
module ival_regs
  import ival_timer_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   we,
  input  logic [HALF_W-1:0] wdata,
  input  logic              expire,
  input  logic [CNT_W-1:0]  cnt,
  output logic              to_q,
  output logic              run_q,
  output logic              ie_q,
  output logic              cont_q,
  output logic [CNT_W-1:0]  period,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  snap,
  output logic              irq_q
);
  logic [HALF_W-1:0] per_lo_q, per_hi_q, per_lo_n, per_hi_n;
  logic              run_n, to_n, ie_n, cont_n;

  assign period = {per_hi_q, per_lo_q};

  always_comb begin
    per_lo_n = we[IX_PLO] ? wdata : per_lo_q;
    per_hi_n = we[IX_PHI] ? wdata : per_hi_q;
    load     = we[IX_PLO] || we[IX_PHI];
    load_val = {per_hi_n, per_lo_n};

    ie_n   = we[IX_CTRL] ? wdata[CT_IE]   : ie_q;
    cont_n = we[IX_CTRL] ? wdata[CT_CONT] : cont_q;

    run_n = run_q;
    if (expire && !cont_q) run_n = 1'b0;
    if (we[IX_CTRL]) begin
      if (wdata[CT_GO] && !run_q) run_n = 1'b1;
      if (wdata[CT_HALT] && run_n) run_n = 1'b0;
    end
    if (load) run_n = 1'b0;

    to_n = to_q;
    if (we[IX_STAT]) to_n = 1'b0;
    if (expire)      to_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_lo_q <= '0;
      per_hi_q <= '0;
      run_q    <= 1'b0;
      to_q     <= 1'b0;
      ie_q     <= 1'b0;
      cont_q   <= 1'b0;
      snap     <= '0;
      irq_q    <= 1'b0;
    end else begin
      per_lo_q <= per_lo_n;
      per_hi_q <= per_hi_n;
      run_q    <= run_n;
      to_q     <= to_n;
      ie_q     <= ie_n;
      cont_q   <= cont_n;
      irq_q    <= to_n && ie_n;
      if (we[IX_SLO] || we[IX_SHI]) snap <= cnt;
    end
  end

  a_r7_timeout_set: assert property (@(posedge clk) disable iff (rst)
    expire |=> to_q);
  a_r8_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    (expire && !cont_q) |=> !run_q);
  a_r5_period_halts: assert property (@(posedge clk) disable iff (rst)
    load |=> !run_q);
  a_r9_status_clear: assert property (@(posedge clk) disable iff (rst)
    (we[IX_STAT] && !expire) |=> !to_q);
  a_r4_start_idle: assert property (@(posedge clk) disable iff (rst)
    (we[IX_CTRL] && wdata[CT_GO] && !wdata[CT_HALT] && !run_q) |=> run_q);
  a_r4_both_idle: assert property (@(posedge clk) disable iff (rst)
    (we[IX_CTRL] && wdata[CT_GO] && wdata[CT_HALT] && !run_q) |=> !run_q);
  a_r10_snap_take: assert property (@(posedge clk) disable iff (rst)
    (we[IX_SLO] || we[IX_SHI]) |=> snap == $past(cnt));
endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * HALF_W;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [NREG-1:0]   we;
  logic              expire, load, to_q, run_q, ie_q, cont_q;
  logic [CNT_W-1:0]  cnt, period, load_val, snap;
  logic [HALF_W-1:0] rd_word;

  ival_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .idx(idx), .we(we)
  );

  ival_regs #(.HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst(rst), .we(we), .wdata(bus_wdata[HALF_W-1:0]),
    .expire(expire), .cnt(cnt), .to_q(to_q), .run_q(run_q), .ie_q(ie_q),
    .cont_q(cont_q), .period(period), .load(load), .load_val(load_val),
    .snap(snap), .irq_q(irq)
  );

  ival_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .load(load), .load_val(load_val),
    .reload(period), .cnt(cnt), .expire(expire)
  );

  always_comb begin
    rd_word = '0;
    case (idx)
      IDX_W'(IX_STAT): begin
        rd_word[ST_TO]  = to_q;
        rd_word[ST_RUN] = run_q;
      end
      IDX_W'(IX_CTRL): begin
        rd_word[CT_IE]   = ie_q;
        rd_word[CT_CONT] = cont_q;
      end
      IDX_W'(IX_PLO): rd_word = period[HALF_W-1:0];
      IDX_W'(IX_PHI): rd_word = period[CNT_W-1:HALF_W];
      IDX_W'(IX_SLO): rd_word = snap[HALF_W-1:0];
      IDX_W'(IX_SHI): rd_word = snap[CNT_W-1:HALF_W];
      default:        rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {{(DATA_W-HALF_W){1'b0}}, rd_word};
  end

  a_r11_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (to_q && ie_q));
  a_r12_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:HALF_W] == '0);
  a_r3_ctrl_narrow: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && idx == IDX_W'(IX_CTRL)) |=> bus_rdata[HALF_W-1:2] == '0);
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/ival_timer_bench.sv
module ival_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_plo, m_phi;
  logic [31:0] m_cnt, m_snap;
  logic        m_to, m_run, m_ie, m_cont;

  always #10 clk = ~clk;

  ival_timer u_ival_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [15:0] exp_rd(input int idx);
    case (idx)
      0: return {14'h0, m_run, m_to};
      1: return {14'h0, m_cont, m_ie};
      2: return m_plo;
      3: return m_phi;
      4: return m_snap[15:0];
      5: return m_snap[31:16];
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_plo = '0; m_phi = '0; m_cnt = '1; m_snap = '0;
    m_to = 0; m_run = 0; m_ie = 0; m_cont = 0;
  endtask

  task automatic model_step(input bit wr, input int idx, input logic [31:0] d);
    bit pw, ex, r, t;
    logic [15:0] nlo, nhi;
    logic [31:0] c;
    pw  = wr && (idx == 2 || idx == 3);
    ex  = m_run && !pw && (m_cnt == 0);
    nlo = (wr && idx == 2) ? d[15:0] : m_plo;
    nhi = (wr && idx == 3) ? d[15:0] : m_phi;
    r = m_run;
    if (ex && !m_cont) r = 0;
    if (wr && idx == 1) begin
      if (d[2] && !m_run) r = 1;
      if (d[3] && r) r = 0;
    end
    if (pw) r = 0;
    t = m_to;
    if (wr && idx == 0) t = 0;
    if (ex) t = 1;
    if (pw) c = {nhi, nlo};
    else if (ex) c = {m_phi, m_plo};
    else if (m_run) c = m_cnt - 1;
    else c = m_cnt;
    if (wr && (idx == 4 || idx == 5)) m_snap = m_cnt;
    if (wr && idx == 1) begin m_ie = d[0]; m_cont = d[1]; end
    m_plo = nlo; m_phi = nhi; m_run = r; m_to = t; m_cnt = c;
  endtask

  task automatic cyc(input bit wr, input bit rd, input logic [4:0] addr,
                     input logic [31:0] d, input string req);
    logic [15:0] e;
    bus_addr = addr; bus_wr = wr; bus_rd = rd; bus_wdata = d;
    e = exp_rd(int'(addr[4:2]));
    @(posedge clk);
    model_step(wr, int'(addr[4:2]), d);
    #5;
    bus_wr = 0; bus_rd = 0;
    if (rd) check(req, bus_rdata, {16'h0, e});
    check("R11 irq", {31'h0, irq}, {31'h0, m_to & m_ie});
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d, input string req);
    cyc(1, 0, a, d, req);
  endtask
  task automatic rd_reg(input logic [4:0] a, input string req);
    cyc(0, 1, a, 32'h0, req);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 5'h0, 32'h0, "R6");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #5 rst = 0;
    // R1: reset state
    for (int i = 0; i < 6; i++) rd_reg(5'(i * 4), "R1 reset read");
    wr_reg(5'd16, 32'h0, "R1");
    rd_reg(5'd16, "R1 reset count low");
    rd_reg(5'd20, "R1 reset count high");
    check("R1 snap high", bus_rdata, 32'h0000_FFFF);
    // R3: only two control bits kept
    wr_reg(5'd4, 32'hFFFF_FFFB, "R3");
    rd_reg(5'd4, "R3 control read");
    check("R3 ctrl", bus_rdata, 32'h3);
    wr_reg(5'd4, 32'h0, "R3");
    // R5: period halves keep low 16 bits
    wr_reg(5'd8, 32'h0001_2345, "R5");
    rd_reg(5'd8, "R5 period low");
    check("R5 plo", bus_rdata, 32'h2345);
    wr_reg(5'd12, 32'h0, "R5");
    // R4: start and stop together on idle timer
    wr_reg(5'd4, 32'hC, "R4");
    rd_reg(5'd0, "R4 both bits idle");
    check("R4 stopped", bus_rdata[1], 1'b0);
    // R6/R10: short period, continuous, snapshots each cycle via odd byte address (R2)
    wr_reg(5'd8, 32'h4, "R5");
    wr_reg(5'd4, 32'h6, "R4");
    rd_reg(5'd0, "R4 started");
    check("R4 running", bus_rdata[1], 1'b1);
    for (int i = 0; i < 8; i++) begin
      wr_reg(5'd17, 32'h0, "R10");
      rd_reg(5'd18, "R10 snapshot low");
    end
    // R7: timeout while continuous
    idle(12);
    rd_reg(5'd1, "R7 timeout flag");
    check("R7 to", bus_rdata[1:0], 2'b11);
    // R9: status write with any data clears
    wr_reg(5'd0, 32'hFFFF_FFFF, "R9");
    rd_reg(5'd0, "R9 cleared");
    // R11: enable interrupt
    wr_reg(5'd4, 32'h3, "R11");
    idle(10);
    // R9 collisions: status clears every clock on a period of 1
    wr_reg(5'd8, 32'h1, "R5");
    wr_reg(5'd4, 32'h7, "R4");
    for (int i = 0; i < 8; i++) begin
      wr_reg(5'd0, 32'h0, "R9");
      rd_reg(5'd0, "R9 race");
    end
    // R8: one-shot
    wr_reg(5'd8, 32'h3, "R5");
    wr_reg(5'd4, 32'h5, "R8");
    idle(8);
    rd_reg(5'd0, "R8 stopped after one shot");
    check("R8 run", bus_rdata[1:0], 2'b01);
    wr_reg(5'd20, 32'h0, "R10");
    rd_reg(5'd16, "R8 holds period");
    check("R8 cnt", bus_rdata, 32'h3);
    // R2: unused indices
    wr_reg(5'd24, 32'hFFFF, "R2");
    wr_reg(5'd28, 32'hFFFF, "R2");
    rd_reg(5'd24, "R2 unused read");
    rd_reg(5'd30, "R2 unused read");
    rd_reg(5'd9, "R2 period untouched");
    rd_reg(5'd6, "R2 ctrl untouched");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int idx, op;
      logic [31:0] d;
      idx = int'($urandom % 8);
      op  = int'($urandom % 3);
      d   = $urandom;
      if (idx == 2) d = $urandom % 6;
      if (idx == 3) d = 32'h0;
      if (idx == 1) d = $urandom % 16;
      if (op == 1)      wr_reg(5'({idx[2:0], 2'($urandom)}), d, "R12 random");
      else if (op == 2) rd_reg(5'({idx[2:0], 2'($urandom)}), "R12 random read");
      else              idle(1);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule